// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This unit serves instruction fetches for a core that can optionally run 16-bit compressed instructions alongside 32-bit ones. The core presents a fetch address and a compressed-mode flag. The unit answers with one 32-bit instruction word. Behind it sits a read port into already-translated memory, which can return either a 16-bit parcel or a 32-bit word.

Two routes exist:

- **Straddling route.** When compressed mode is on and the address sits two bytes past a word boundary, the instruction may cross that boundary. The unit reads one parcel at the fetch address. It reads a second parcel two bytes higher only when the first parcel's low bits mark a full-length instruction. This route never touches the fetch cache.
- **Cached route.** Every other fetch goes through a small direct-mapped fetch cache. The cache keeps the complete fetch address as its tag. It is refilled from memory with a word read on a miss.

A one-cycle flush pulse empties the cache.

Both data interfaces use valid/ready. The request is taken on a cycle where `req_valid` and `req_ready` are both high, and only one fetch is in flight at a time. The response is offered with `rsp_valid` and held unchanged until `rsp_ready` is seen high. The core may stall it for any number of cycles. The memory request follows the same hold rule against `mem_req_ready`. The memory answers with a single-cycle `mem_rsp_valid` pulse, which the unit always accepts, with at most one read outstanding.

Top module: `ifetch_unit`

## Requirements
- R1: A fetch takes the straddling route exactly when `req_cmode` is 1 and `req_addr[1:0]` is 2'b10. That route first issues a parcel read (`mem_req_half`=1) at the fetch address.
- R2: A parcel is compressed when its bits [1:0] differ from 2'b11. A compressed first parcel ends the fetch after one read, with `rsp_insn` = {16'h0000, parcel}.
- R3: A full-length first parcel (bits [1:0] = 2'b11) causes a second parcel read at fetch address + 2. The response is then {second parcel, first parcel}.
- R4: A straddling fetch neither reads nor writes the fetch cache. A later cached-route fetch of the same address still misses.
- R5: A cached-route fetch hits when the entry at index `addr[9:2]` (2^IDX_W entries) is valid and its tag equals the whole fetch address. A hit returns the stored word with no memory request, and `rsp_valid` rises in the cycle after acceptance.
- R6: A cached-route miss issues one word read (`mem_req_half`=0) at the fetch address. It answers with the returned word and overwrites the indexed entry with that address and word, marking it valid.
- R7: A one-cycle `flush` pulse invalidates every entry, so the next cached-route fetch of any address misses. A flush in the same cycle as a refill leaves that entry invalid.
- R8: `req_ready` is high only while no fetch is in flight. It is low while a response is pending.
- R9: While `rsp_valid` is high and `rsp_ready` low, `rsp_valid` stays high and `rsp_insn` stays unchanged.
- R10: A memory request keeps `mem_req_valid`, `mem_req_addr` and `mem_req_half` unchanged until accepted, and at most one read is outstanding.
- R11: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every cache entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all fetch cache entries |
| req_valid | input | 1 | Fetch request offered |
| req_ready | output | 1 | Unit can take a fetch |
| req_addr | input | ADDR_W | Fetch address |
| req_cmode | input | 1 | Compressed mode enabled |
| rsp_valid | output | 1 | Instruction available |
| rsp_ready | input | 1 | Core takes the instruction |
| rsp_insn | output | 32 | Fetched instruction |
| mem_req_valid | output | 1 | Memory read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | Read address |
| mem_req_half | output | 1 | 1 = 16-bit parcel read, 0 = 32-bit word read |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | 32 | Read data; a parcel arrives in bits 15:0 |

## Verification
Suppose a valid bit or tag is left behind after a flush or a conflicting refill. The unit then returns a stale word with no memory traffic on the very next fetch of that address. The bench exposes this by changing memory contents between fetches and counting word and parcel reads per fetch. If the straddling route wrongly fills the cache, the effect is delayed: it only appears when a later cached-route fetch of the same address hits instead of issuing a word read. A wrong route or parcel-ordering choice shows on the response itself, as a swapped or zero upper half, or as an extra or missing parcel read in the same fetch.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int PARCEL_W = 16;
  localparam int INSN_W   = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_WWAIT,
    ST_LREQ,
    ST_LWAIT,
    ST_HREQ,
    ST_HWAIT,
    ST_RESP
  } ifu_state_e;

  // A parcel starts a full-length instruction when its two low bits are both set.
  function automatic logic is_full_len(input logic [1:0] lsb);
    return lsb == 2'b11;
  endfunction
endpackage

// File: rtl/ifu_cache.sv
module ifu_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [ADDR_W-1:0]        lk_addr,
  output logic                     lk_hit,
  output logic [ifu_pkg::INSN_W-1:0] lk_data,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [ifu_pkg::INSN_W-1:0] wr_data,
  output logic                     empty
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]           valid_q;
  logic [ADDR_W-1:0]          tag_q  [DEPTH];
  logic [ifu_pkg::INSN_W-1:0] data_q [DEPTH];
  logic [IDX_W-1:0]           lk_idx;
  logic [IDX_W-1:0]           wr_idx;

  assign lk_idx = lk_addr[IDX_W+1:2];
  assign wr_idx = wr_addr[IDX_W+1:2];

  // Flush has priority over a refill landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_addr;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_addr);
  assign lk_data = data_q[lk_idx];
  assign empty   = ~|valid_q;
endmodule

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cmode,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [INSN_W-1:0] rsp_insn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_half,
  input  logic              mem_rsp_valid,
  input  logic [INSN_W-1:0] mem_rsp_data,
  input  logic              lk_hit,
  input  logic [INSN_W-1:0] lk_data,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [INSN_W-1:0] fill_data
);
  ifu_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [INSN_W-1:0] insn_q;
  logic              split_req;
  logic              accept;

  assign split_req = req_cmode && (req_addr[1:0] == 2'b10);
  assign accept    = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = split_req ? ST_LREQ : (lk_hit ? ST_RESP : ST_WREQ);
      ST_WREQ:  if (mem_req_ready) state_d = ST_WWAIT;
      ST_WWAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_LREQ:  if (mem_req_ready) state_d = ST_LWAIT;
      ST_LWAIT: if (mem_rsp_valid)
                  state_d = is_full_len(mem_rsp_data[1:0]) ? ST_HREQ : ST_RESP;
      ST_HREQ:  if (mem_req_ready) state_d = ST_HWAIT;
      ST_HWAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      insn_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        if (!split_req && lk_hit) insn_q <= lk_data;
      end
      if (mem_rsp_valid) begin
        unique case (state_q)
          ST_WWAIT: insn_q <= mem_rsp_data;
          ST_LWAIT: insn_q <= {{(INSN_W-PARCEL_W){1'b0}}, mem_rsp_data[PARCEL_W-1:0]};
          ST_HWAIT: insn_q <= {mem_rsp_data[PARCEL_W-1:0], insn_q[PARCEL_W-1:0]};
          default:  insn_q <= insn_q;
        endcase
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_insn      = insn_q;
  assign mem_req_valid = (state_q == ST_WREQ) || (state_q == ST_LREQ) || (state_q == ST_HREQ);
  assign mem_req_half  = (state_q == ST_LREQ) || (state_q == ST_HREQ);
  assign mem_req_addr  = (state_q == ST_HREQ) ? addr_q + ADDR_W'(2) : addr_q;
  assign fill_en       = (state_q == ST_WWAIT) && mem_rsp_valid;
  assign fill_addr     = addr_q;
  assign fill_data     = mem_rsp_data;
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cmode,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_insn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_half,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  logic              cache_hit;
  logic [31:0]       cache_data;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_addr;
  logic [31:0]       fill_data;
  logic              cache_empty;

  ifu_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .lk_addr (req_addr),
    .lk_hit  (cache_hit),
    .lk_data (cache_data),
    .wr_en   (fill_en),
    .wr_addr (fill_addr),
    .wr_data (fill_data),
    .empty   (cache_empty)
  );

  ifu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_cmode     (req_cmode),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_insn      (rsp_insn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_half  (mem_req_half),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lk_hit        (cache_hit),
    .lk_data       (cache_data),
    .fill_en       (fill_en),
    .fill_addr     (fill_addr),
    .fill_data     (fill_data)
  );
endmodule

// File: rtl/ifetch_chk.sv
module ifetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_cmode,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_insn,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_half,
  input logic              cache_hit,
  input logic              fill_en,
  input logic              cache_empty
);
  logic last_half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_half_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) last_half_q <= mem_req_half;
  end

  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_insn)));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_half)));

  a_r4_no_fill_from_parcel: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !last_half_q);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cache_empty);

  a_r5_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cache_hit && !(req_cmode && req_addr[1:0] == 2'b10))
      |=> (rsp_valid && !mem_req_valid));
endmodule

bind ifetch_unit ifetch_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ifetch_unit.sv
`timescale 1ns/1ps
module tb_ifetch_unit;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 8;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_cmode = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [31:0]       rsp_insn;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_req_half;
  logic              mem_rsp_valid;
  logic [31:0]       mem_rsp_data;

  int checks = 0;
  int failures = 0;
  int word_reads = 0;
  int half_reads = 0;
  logic [31:0] gen = 32'h1;

  logic [31:0] m_tag [DEPTH];
  logic [31:0] m_data [DEPTH];
  bit          m_val [DEPTH];

  always #2 clk = ~clk;

  ifetch_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (.*);

  function automatic logic [15:0] hw(input logic [31:0] a, input logic [31:0] g);
    logic [31:0] x;
    x = ({1'b0, a[31:1]} * 32'h9E3779B1) + (g * 32'h85EBCA6B);
    x = x ^ (x >> 15);
    return x[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: random acceptance, 0..2 cycle return latency.
  initial begin
    logic [31:0] a;
    logic        h;
    logic        pend;
    logic [31:0] pa;
    logic        ph;
    pend = 1'b0; pa = '0; ph = 1'b0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rst_n && pend) begin
        // R10: held request must not change while waiting for acceptance
        chk(mem_req_valid && mem_req_addr == pa && mem_req_half == ph, "R10 hold",
            mem_req_addr, pa);
      end
      mem_req_ready = ($urandom % 4) != 0;
      pend = mem_req_valid && !mem_req_ready;
      pa = mem_req_addr; ph = mem_req_half;
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr; h = mem_req_half;
        if (h) half_reads++; else word_reads++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        pend = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = h ? {16'h0000, hw(a, gen)} : {hw(a + 32'd2, gen), hw(a, gen)};
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, input logic cm);
    logic [31:0] exp;
    logic [15:0] lo;
    int   exp_w, exp_h, w0, h0;
    bit   split, hit;
    int   idx;
    logic [31:0] held;
    string tag;
    split = cm && (a[1:0] == 2'b10);
    hit = 1'b0;
    idx = int'(a[IDX_W+1:2]);
    if (split) begin
      lo = hw(a, gen);
      exp_w = 0;
      if (lo[1:0] != 2'b11) begin exp = {16'h0000, lo}; exp_h = 1; tag = "R2 compressed parcel"; end
      else begin exp = {hw(a + 32'd2, gen), lo}; exp_h = 2; tag = "R3 straddling pair"; end
    end else if (m_val[idx] && m_tag[idx] == a) begin
      hit = 1'b1; exp = m_data[idx]; exp_w = 0; exp_h = 0; tag = "R5 cache hit";
    end else begin
      exp = {hw(a + 32'd2, gen), hw(a, gen)}; exp_w = 1; exp_h = 0; tag = "R6 cache miss";
      m_val[idx] = 1'b1; m_tag[idx] = a; m_data[idx] = exp;
    end
    w0 = word_reads; h0 = half_reads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmode = cm;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) chk(rsp_valid === 1'b1 && mem_req_valid === 1'b0, "R5 hit latency",
                 {31'd0, rsp_valid}, 32'd1);
    while (!rsp_valid) @(negedge clk);
    chk(req_ready === 1'b0, "R8 busy while response pending", {31'd0, req_ready}, 32'd0);
    held = rsp_insn;
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_insn === held, "R9 response hold", rsp_insn, held);
    end
    chk(rsp_insn === exp, tag, rsp_insn, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    // R1/R4: route choice seen in read kinds; split route issues no word read
    chk(word_reads - w0 == exp_w, {tag, " word reads (R1 R4)"}, 32'(word_reads - w0), 32'(exp_w));
    chk(half_reads - h0 == exp_h, {tag, " parcel reads (R1)"}, 32'(half_reads - h0), 32'(exp_h));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_val[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a, sc, sf;
    int wb;
    void'($urandom(32'd7));
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R11 reset outputs",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R11 after release", {31'd0, req_ready}, 32'd1);

    a = 32'h0000_0100;
    do_fetch(a, 1'b0);                  // R6 miss
    do_fetch(a, 1'b0);                  // R5 hit
    gen = gen + 32'd1;
    do_fetch(a, 1'b0);                  // R5 hit returns stored word despite new memory
    do_fetch(a + 32'h400, 1'b0);        // R6 same index, evicts
    do_fetch(a, 1'b0);                  // R6 misses again
    do_fetch(a | 32'd2, 1'b0);          // R5 tag must match full address
    do_fetch(a, 1'b1);                  // R1 word-aligned in compressed mode uses cache

    // R1 R2 R3 R4: find compressed and full-length first parcels
    sc = '0; sf = '0;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] t;
      t = 32'h0000_2002 + 32'(k * 4);
      if (hw(t, gen) [1:0] != 2'b11 && sc == '0) sc = t;
      if (hw(t, gen) [1:0] == 2'b11 && sf == '0) sf = t;
    end
    do_fetch(sc, 1'b1);
    do_fetch(sf, 1'b1);
    wb = word_reads;
    do_fetch(sf, 1'b0);                 // R4 split did not fill: word read happens
    chk(word_reads - wb == 1, "R4 later cached fetch misses", 32'(word_reads - wb), 32'd1);

    // R7 flush
    do_fetch(a, 1'b0);
    do_flush();
    wb = word_reads;
    do_fetch(a, 1'b0);
    chk(word_reads - wb == 1, "R7 flush invalidates", 32'(word_reads - wb), 32'd1);

    for (int n = 0; n < 400; n++) begin
      a = 32'h0000_4000 + 32'(($urandom % 96) * 2) + ((($urandom % 4) == 0) ? 32'h400 : 32'h0);
      if (($urandom % 16) == 0) gen = gen + 32'd1;
      if (($urandom % 32) == 0) do_flush();
      do_fetch(a, 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule